// File: doc/BRIEF.md
# Receive I/Q sample word unpacker

This block sits behind the capture stage of a narrow receive data link. Each clock it takes one 6-bit word and one frame strobe level. It rebuilds 12-bit two's-complement I and Q samples for one or two channels. Every sample crosses the bus as two halves, the upper six bits first and the lower six bits later. The I and Q halves of a channel interleave in a fixed four-word pattern.

The rising edge of the frame strobe marks the start of a group and realigns the internal slot counter. In two-channel mode a group is eight words: channel 1's four words, then channel 2's four. The strobe is high for the first four and low for the last four. In one-channel mode a group is four words, and the strobe is high for the two upper halves. The slots of a disabled channel still occupy the bus but are discarded.

Every finished group gives a one-cycle valid pulse for each enabled channel. A framing-error pulse flags a strobe level that does not fit the current slot, or a rising edge that arrives mid-group.

Top module: `iq_word_unpacker`

## Requirements
- R1: After reset all sample outputs are 0, and ch1_valid, ch2_valid and frame_err are low.
- R2: Until the first low-to-high transition of frame_in after reset, no valid pulse and no frame_err occur, whatever word_in carries.
- R3: A sample is {upper word, lower word}, and bit 5 of each word is its most significant bit. Upper 0x1F with lower 0x3F gives 0x7FF. Upper 0x20 with lower 0x00 gives 0x800.
- R4: With dual_mode=0 a group is four words in the order I upper, Q upper, I lower, Q lower. frame_in is 1 for the first two words and 0 for the last two. ch1_valid pulses for one cycle, with ch1_i and ch1_q, on the clock edge after the edge that captured the Q lower word.
- R5: With dual_mode=1 a group is eight words: channel 1 in the R4 order, then channel 2 in the same order. frame_in is 1 for words 1 to 4 and 0 for words 5 to 8. ch1_valid pulses one cycle after word 4 and ch2_valid one cycle after word 8.
- R6: ch_en bit 0 enables channel 1 and bit 1 enables channel 2. A disabled channel gives no valid pulse and its sample outputs keep their values. ch2_valid never pulses when dual_mode=0.
- R7: Once aligned, a frame_in level that differs from the level R4 or R5 gives for the current slot raises frame_err for one cycle. The pulse comes on the edge after the edge that captured the word.
- R8: A rising edge of frame_in that arrives when the slot counter is not at the start of a group raises frame_err on the next edge. The word carrying that edge is taken as the I upper word of a new group.
- R9: Sample outputs change only on the cycle where the channel's valid pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | 6 | Captured bus word, bit 5 most significant |
| frame_in | input | 1 | Frame strobe sampled with the word |
| dual_mode | input | 1 | 1: two channels, eight-word groups; 0: one channel, four-word groups |
| ch_en | input | 2 | Channel enables, bit 0 channel 1, bit 1 channel 2 |
| ch1_i | output | 12 | Channel 1 I sample |
| ch1_q | output | 12 | Channel 1 Q sample |
| ch1_valid | output | 1 | One-cycle pulse, new channel 1 pair |
| ch2_i | output | 12 | Channel 2 I sample |
| ch2_q | output | 12 | Channel 2 Q sample |
| ch2_valid | output | 1 | One-cycle pulse, new channel 2 pair |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
Every result is registered once. A valid pulse, its sample pair and a frame_err pulse all appear on the clock edge after the edge that captured the triggering word. Inputs are driven at the falling edge, and each word is followed by one rising edge. Outputs are read 2 ns after that edge, so every reading belongs to the word just sent. Valid pulses are checked after the last word of each channel and are checked to be absent after the other channel's last word. The sample outputs are compared at the end of every group with a bench model that changes only when an enabled channel completes.

// File: rtl/iqu_pkg.sv
package iqu_pkg;
  localparam int WORD_W   = 6;
  localparam int SAMPLE_W = 2 * WORD_W;
  localparam int LANES    = 2;
  localparam int SLOT_W   = 3;
  localparam int POS_W    = 2;

  // Upper half above lower half.
  function automatic logic [SAMPLE_W-1:0] join_halves(
    input logic [WORD_W-1:0] hi,
    input logic [WORD_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Index of the final slot of a group.
  function automatic logic [SLOT_W-1:0] last_slot(input logic dual);
    return dual ? SLOT_W'(7) : SLOT_W'(3);
  endfunction

  // Strobe level a well-formed group carries in slot s.
  function automatic logic frame_expected(input logic dual,
                                          input logic [SLOT_W-1:0] s);
    return dual ? (s < SLOT_W'(4)) : (s < SLOT_W'(2));
  endfunction

  // Channel owning slot s (0 = channel 1).
  function automatic logic lane_of(input logic dual,
                                   input logic [SLOT_W-1:0] s);
    return dual ? s[2] : 1'b0;
  endfunction
endpackage

// File: rtl/iqu_slot_tracker.sv
module iqu_slot_tracker
  import iqu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_in,
  input  logic              dual_mode,
  output logic              rise_evt,
  output logic              locked,
  output logic              active,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_now,
  output logic              frame_err
);
  logic frame_q;
  logic mismatch;
  logic late_rise;
  logic [SLOT_W-1:0] slot_next;

  assign rise_evt  = frame_in & ~frame_q;
  assign slot_now  = rise_evt ? '0 : slot_q;
  assign active    = rise_evt | locked;
  assign mismatch  = active & (frame_in != frame_expected(dual_mode, slot_now));
  assign late_rise = rise_evt & locked & (slot_q != '0);

  always_comb begin
    if (slot_now >= last_slot(dual_mode)) slot_next = '0;
    else slot_next = SLOT_W'(slot_now + SLOT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q   <= 1'b0;
      locked    <= 1'b0;
      slot_q    <= '0;
      frame_err <= 1'b0;
    end else begin
      frame_q   <= frame_in;
      frame_err <= mismatch | late_rise;
      if (rise_evt) locked <= 1'b1;
      if (active) slot_q <= slot_next;
    end
  end
endmodule

// File: rtl/iqu_lane_assembler.sv
module iqu_lane_assembler
  import iqu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                sel,
  input  logic [POS_W-1:0]    pos,
  input  logic                enable,
  output logic [SAMPLE_W-1:0] samp_i,
  output logic [SAMPLE_W-1:0] samp_q,
  output logic                valid
);
  logic [WORD_W-1:0] i_hi, q_hi, i_lo;
  logic emit;

  assign emit = sel & (pos == POS_W'(3)) & enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_hi   <= '0;
      q_hi   <= '0;
      i_lo   <= '0;
      samp_i <= '0;
      samp_q <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= emit;
      if (sel) begin
        case (pos)
          2'd0: i_hi <= word_in;
          2'd1: q_hi <= word_in;
          2'd2: i_lo <= word_in;
          default: ;
        endcase
      end
      if (emit) begin
        samp_i <= join_halves(i_hi, i_lo);
        samp_q <= join_halves(q_hi, word_in);
      end
    end
  end
endmodule

// File: rtl/iq_word_unpacker.sv
module iq_word_unpacker
  import iqu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   word_in,
  input  logic                frame_in,
  input  logic                dual_mode,
  input  logic [LANES-1:0]    ch_en,
  output logic [SAMPLE_W-1:0] ch1_i,
  output logic [SAMPLE_W-1:0] ch1_q,
  output logic                ch1_valid,
  output logic [SAMPLE_W-1:0] ch2_i,
  output logic [SAMPLE_W-1:0] ch2_q,
  output logic                ch2_valid,
  output logic                frame_err
);
  logic              rise_evt;
  logic              locked;
  logic              active;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] slot_now;
  logic              cur_lane;

  logic [SAMPLE_W-1:0] lane_i [LANES];
  logic [SAMPLE_W-1:0] lane_q [LANES];
  logic [LANES-1:0]    lane_valid;

  iqu_slot_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_in  (frame_in),
    .dual_mode (dual_mode),
    .rise_evt  (rise_evt),
    .locked    (locked),
    .active    (active),
    .slot_q    (slot_q),
    .slot_now  (slot_now),
    .frame_err (frame_err)
  );

  assign cur_lane = lane_of(dual_mode, slot_now);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_sel;
    assign lane_sel = active & (cur_lane == 1'(g)) & ((g == 0) | dual_mode);
    iqu_lane_assembler u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_in (word_in),
      .sel     (lane_sel),
      .pos     (slot_now[POS_W-1:0]),
      .enable  (ch_en[g]),
      .samp_i  (lane_i[g]),
      .samp_q  (lane_q[g]),
      .valid   (lane_valid[g])
    );
  end

  assign ch1_i     = lane_i[0];
  assign ch1_q     = lane_q[0];
  assign ch1_valid = lane_valid[0];
  assign ch2_i     = lane_i[1];
  assign ch2_q     = lane_q[1];
  assign ch2_valid = lane_valid[1];
endmodule

// File: rtl/iqu_checker.sv
module iqu_checker
  import iqu_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                dual_mode,
  input logic [LANES-1:0]    ch_en,
  input logic [SAMPLE_W-1:0] ch1_i,
  input logic [SAMPLE_W-1:0] ch1_q,
  input logic                ch1_valid,
  input logic [SAMPLE_W-1:0] ch2_i,
  input logic [SAMPLE_W-1:0] ch2_q,
  input logic                ch2_valid,
  input logic                frame_err,
  input logic                locked,
  input logic                rise_evt,
  input logic [SLOT_W-1:0]   slot_q
);
  AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !rise_evt) |=> (!ch1_valid && !ch2_valid && !frame_err)); // R2
  AST_LATE_RISE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && locked && slot_q != '0) |=> frame_err); // R8
  AST_NO_CH2_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_mode |=> !ch2_valid); // R6
  AST_CH1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[0] |=> !ch1_valid); // R6
  AST_CH2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en[1] |=> !ch2_valid); // R6
  AST_CH1_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    ch1_valid |=> !ch1_valid); // R4
  AST_HOLD_CH1: assert property (@(posedge clk) disable iff (!rst_n)
    !ch1_valid |-> ($stable(ch1_i) && $stable(ch1_q))); // R9
  AST_HOLD_CH2: assert property (@(posedge clk) disable iff (!rst_n)
    !ch2_valid |-> ($stable(ch2_i) && $stable(ch2_q))); // R9
endmodule

bind iq_word_unpacker iqu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dual_mode (dual_mode),
  .ch_en     (ch_en),
  .ch1_i     (ch1_i),
  .ch1_q     (ch1_q),
  .ch1_valid (ch1_valid),
  .ch2_i     (ch2_i),
  .ch2_q     (ch2_q),
  .ch2_valid (ch2_valid),
  .frame_err (frame_err),
  .locked    (locked),
  .rise_evt  (rise_evt),
  .slot_q    (slot_q)
);

// File: tb/sim_iq_word_unpacker.sv
`timescale 1ns/1ps
module sim_iq_word_unpacker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] word_in = '0;
  logic frame_in = 1'b0;
  logic dual_mode = 1'b0;
  logic [1:0] ch_en = 2'b00;
  logic [11:0] ch1_i, ch1_q, ch2_i, ch2_q;
  logic ch1_valid, ch2_valid, frame_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [11:0] e1i = '0, e1q = '0, e2i = '0, e2q = '0;

  always #5 clk = ~clk;

  iq_word_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .frame_in(frame_in),
    .dual_mode(dual_mode), .ch_en(ch_en),
    .ch1_i(ch1_i), .ch1_q(ch1_q), .ch1_valid(ch1_valid),
    .ch2_i(ch2_i), .ch2_q(ch2_q), .ch2_valid(ch2_valid),
    .frame_err(frame_err)
  );

  typedef struct packed {
    logic        dual;
    logic [1:0]  en;
    logic [11:0] i1, q1, i2, q2;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b01, 12'h7FF, 12'h800, 12'h000, 12'h000},
    '{1'b0, 2'b01, 12'h123, 12'hABC, 12'h000, 12'h000},
    '{1'b1, 2'b11, 12'h800, 12'h7FF, 12'h555, 12'hAAA},
    '{1'b1, 2'b01, 12'h001, 12'hFFE, 12'h3C3, 12'h0F0},
    '{1'b1, 2'b10, 12'h111, 12'h222, 12'h333, 12'h444},
    '{1'b0, 2'b11, 12'h456, 12'h789, 12'h000, 12'h000},
    '{1'b0, 2'b00, 12'h0AA, 12'h0BB, 12'h000, 12'h000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, clock once, settle: outputs then belong to this word.
  task automatic send(input logic [5:0] w, input logic f);
    @(negedge clk);
    word_in = w;
    frame_in = f;
    @(posedge clk);
    #2;
  endtask

  task automatic send_group(input vec_t v);
    bit err_seen;
    err_seen = 0;
    dual_mode = v.dual;
    ch_en = v.en;
    send(v.i1[11:6], 1'b1); err_seen |= frame_err;
    send(v.q1[11:6], 1'b1); err_seen |= frame_err;
    send(v.i1[5:0], v.dual); err_seen |= frame_err;
    send(v.q1[5:0], v.dual); err_seen |= frame_err;
    check("R4 R5 ch1_valid after channel 1 last word", ch1_valid, v.en[0]);
    check("R6 ch2_valid quiet after channel 1 word", ch2_valid, 0);
    if (v.en[0]) begin e1i = v.i1; e1q = v.q1; end
    if (v.dual) begin
      send(v.i2[11:6], 1'b0); err_seen |= frame_err;
      send(v.q2[11:6], 1'b0); err_seen |= frame_err;
      send(v.i2[5:0], 1'b0); err_seen |= frame_err;
      send(v.q2[5:0], 1'b0); err_seen |= frame_err;
      check("R5 ch2_valid after word 8", ch2_valid, v.en[1]);
      check("R5 ch1_valid quiet after word 8", ch1_valid, 0);
      if (v.en[1]) begin e2i = v.i2; e2q = v.q2; end
    end
    check("R7 no frame_err on well-formed group", err_seen, 0);
    check("R3 R9 ch1_i", ch1_i, e1i);
    check("R3 R9 ch1_q", ch1_q, e1q);
    check("R6 R9 ch2_i", ch2_i, e2i);
    check("R6 R9 ch2_q", ch2_q, e2q);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset ch1_i", ch1_i, 0);
    check("R1 reset ch2_q", ch2_q, 0);
    check("R1 reset valids", {ch1_valid, ch2_valid}, 0);
    check("R1 reset frame_err", frame_err, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: words before any frame rise are ignored.
    begin
      bit seen;
      seen = 0;
      ch_en = 2'b11;
      dual_mode = 1'b1;
      for (int k = 0; k < 6; k++) begin
        send(6'(k * 11 + 3), 1'b0);
        seen |= ch1_valid | ch2_valid | frame_err;
      end
      check("R2 quiet before first rise", seen, 0);
      check("R2 ch1_i untouched", ch1_i, 0);
    end

    for (int n = 0; n < NV; n++) send_group(VECS[n]);

    // R7: strobe held high into slot 3 of a one-channel group.
    dual_mode = 1'b0; ch_en = 2'b01;
    send(6'h01, 1'b1);
    send(6'h02, 1'b1);
    send(6'h03, 1'b1);
    check("R7 frame_err after wrong level", frame_err, 1);
    send(6'h04, 1'b0);
    check("R7 frame_err clears on right level", frame_err, 0);

    // R8: rise in slot 4 of a group resyncs; that word is I upper.
    send(6'h05, 1'b1);
    send(6'h06, 1'b1);
    send(6'h07, 1'b0);
    send(6'h2A, 1'b1);
    check("R8 frame_err on mid-group rise", frame_err, 1);
    send(6'h05, 1'b1);
    check("R8 no error after resync", frame_err, 0);
    send(6'h25, 1'b0);
    send(6'h1A, 1'b0);
    check("R8 ch1_valid after resynced group", ch1_valid, 1);
    check("R8 R3 ch1_i rebuilt from resync word", ch1_i, 12'hAA5);
    check("R8 R3 ch1_q", ch1_q, 12'h15A);
    send(6'h00, 1'b0);
    check("R4 valid is one cycle", ch1_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule